// File: doc/BRIEF.md
# Four-Mode Interrupting GPIO Port

This peripheral gives software control over a bank of general-purpose pins through a small word-addressed register bus. Each pin can be enabled as an input, as an output, or both. Driven values come from an output value register combined with a per-pin inversion mask. Sampled values pass through a two-flop synchronizer, and disabled inputs are forced to zero.

Every pin can watch for four kinds of events: rising edge, falling edge, high level and low level. Each kind has a pending register that records events whether or not the kind is enabled, and a separate enable register. A single interrupt request goes to the system interrupt controller whenever any pending bit meets its enable. Software clears pending bits by writing ones. A level event that is still present sets its bit again at once. A testbench can loop the driven pins back into the inputs to exercise the whole path.

Top module: `gpio4i`

## Requirements
- R1: After reset, the pad output enables, pad outputs, interrupt request, input value (byte offset 0x00) and rise pending (0x1C) all read zero. Because every input starts disabled, low pending (0x34) reads all ones.
- R2: The pad output equals (output value at 0x0C XOR inversion mask at 0x40) AND output enable at 0x08. The pad output enable equals the output enable register. The inversion mask reads back as written. The pad outputs change only after a register write.
- R3: The input value at 0x00 reads the synchronized pin value ANDed with the input enable at 0x04. Disabled pins read zero.
- R4: A pin change applied before clock edge A is seen by a read sampled at edge A+2, and not by reads at A or A+1.
- R5: A 0-to-1 change of the gated input sets rise pending (0x1C), and a 1-to-0 change sets fall pending (0x24). Both are set even when the rise enable (0x18) and fall enable (0x20) are zero, and then no interrupt is raised.
- R6: Writing to a pending register clears exactly the bit positions written as 1. Bits written as 0 keep their value.
- R7: High pending (0x2C) sets every cycle the gated input is 1, and low pending (0x34) every cycle it is 0. A clear of a pin still at that level reads back as set.
- R8: The interrupt request is the OR over all pins of (rise pend&en | fall pend&en | high pend&en | low pend&en), using enables at 0x18, 0x20, 0x28 and 0x30. Clearing the enable or the pending bit drops it.
- R9: Clearing the input enable of a pin that is high acts as a falling transition and sets its fall and low pending bits.
- R10: When a clear write and a new event hit the same pending bit in the same cycle, the bit ends set. Other bits in the clear mask are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus access strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| pad_in | input | 32 | Raw pin levels from the pads |
| pad_out | output | 32 | Values driven onto the pads |
| pad_oe | output | 32 | Per-pin drive enable |
| irq | output | 1 | Interrupt request to the interrupt controller |

## Verification
A software write that clears a pending register can land in the very cycle in which the edge detector reports a new event on a pin in the clear mask. The bench first leaves one pin's rise bit pending. It then raises a second pin and times a clear write covering both pins to reach the same clock edge as the second pin's detected rise, two synchronizer cycles plus one detect cycle after the pin change. It judges the result by reading the rise pending register: the new event must survive and the old bit must be gone. The level-kind counterpart, a clear of a high pending bit while the pin stays high, is judged the same way by readback.

// File: rtl/gpio4i_pkg.sv
package gpio4i_pkg;

  localparam int unsigned KINDS = 4;

  typedef enum logic [1:0] {
    K_RISE = 2'd0,
    K_FALL = 2'd1,
    K_HIGH = 2'd2,
    K_LOW  = 2'd3
  } irq_kind_e;

  localparam logic [7:0] OFS_IN_VAL    = 8'h00;
  localparam logic [7:0] OFS_IN_EN     = 8'h04;
  localparam logic [7:0] OFS_OUT_EN    = 8'h08;
  localparam logic [7:0] OFS_OUT_VAL   = 8'h0C;
  localparam logic [7:0] OFS_KIND_BASE = 8'h18;
  localparam logic [7:0] OFS_INV_MASK  = 8'h40;

  // enable register of kind k; its pending register sits 4 bytes above
  function automatic logic [7:0] en_ofs(input int unsigned k);
    return OFS_KIND_BASE + 8'(k * 8);
  endfunction

  function automatic logic [7:0] pend_ofs(input int unsigned k);
    return OFS_KIND_BASE + 8'(k * 8) + 8'h04;
  endfunction

endpackage

// File: rtl/gpio4i_sync.sv
module gpio4i_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stage_q;
  logic [STAGES-1:0][W-1:0] stage_d;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign stage_d[s] = d;
    end else begin : g_rest
      assign stage_d[s] = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d[s];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio4i_detect.sv
module gpio4i_detect
  import gpio4i_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [W-1:0]          sync_in,
  input  logic [W-1:0]          in_en,
  output logic [W-1:0]          in_val,
  output logic [KINDS-1:0][W-1:0] evt
);

  logic [W-1:0] prev_q;
  logic [W-1:0] gated;

  assign gated  = sync_in & in_en;
  assign in_val = gated;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= gated;
  end

  always_comb begin
    evt         = '0;
    evt[K_RISE] = gated & ~prev_q;
    evt[K_FALL] = ~gated & prev_q;
    evt[K_HIGH] = gated;
    evt[K_LOW]  = ~gated;
  end

endmodule

// File: rtl/gpio4i_pend.sv
module gpio4i_pend #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         clr_stb,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] pend
);

  logic [W-1:0] pend_q;
  logic [W-1:0] pend_d;
  logic         pend_upd;

  always_comb begin
    pend_upd = clr_stb | (|set_vec);
    pend_d   = pend_q;
    if (clr_stb) pend_d = pend_d & ~clr_mask;
    pend_d   = pend_d | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend_q <= '0;
    else if (pend_upd) pend_q <= pend_d;
  end

  assign pend = pend_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((pend & $past(set_vec)) == $past(set_vec))); // R10

  AST_DROP_NEEDS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    ((~pend & $past(pend)) != '0) |->
      ($past(clr_stb) && ((~pend & $past(pend) & ~$past(clr_mask)) == '0))); // R6

endmodule

// File: rtl/gpio4i.sv
module gpio4i
  import gpio4i_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [NPINS-1:0]  req_wdata,
  output logic [NPINS-1:0]  rsp_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              irq
);

  localparam int W = NPINS;

  logic wr_stb;
  logic rd_stb;

  logic [W-1:0] in_en_q,  in_en_d;
  logic [W-1:0] out_en_q, out_en_d;
  logic [W-1:0] out_val_q, out_val_d;
  logic [W-1:0] inv_q,    inv_d;
  logic [KINDS-1:0][W-1:0] ie_q, ie_d;
  logic [KINDS-1:0][W-1:0] pend;
  logic [KINDS-1:0][W-1:0] evt;
  logic [KINDS-1:0]        clr_stb;
  logic [W-1:0] rdata_q, rdata_d;
  logic [W-1:0] sync_in;
  logic [W-1:0] in_val;
  logic         cfg_upd;

  assign wr_stb = req_valid & req_write;
  assign rd_stb = req_valid & ~req_write;

  // ---------------- input path ----------------
  gpio4i_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (sync_in)
  );

  gpio4i_detect #(.W(W)) u_detect (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_in (sync_in),
    .in_en   (in_en_q),
    .in_val  (in_val),
    .evt     (evt)
  );

  // ---------------- pending banks ----------------
  for (genvar k = 0; k < KINDS; k++) begin : g_kind
    assign clr_stb[k] = wr_stb && (req_addr == ADDR_W'(pend_ofs(k)));

    gpio4i_pend #(.W(W)) u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_vec  (evt[k]),
      .clr_stb  (clr_stb[k]),
      .clr_mask (req_wdata),
      .pend     (pend[k])
    );
  end

  // ---------------- configuration registers ----------------
  always_comb begin
    in_en_d   = in_en_q;
    out_en_d  = out_en_q;
    out_val_d = out_val_q;
    inv_d     = inv_q;
    ie_d      = ie_q;
    if (wr_stb) begin
      if (req_addr == ADDR_W'(OFS_IN_EN))    in_en_d   = req_wdata;
      if (req_addr == ADDR_W'(OFS_OUT_EN))   out_en_d  = req_wdata;
      if (req_addr == ADDR_W'(OFS_OUT_VAL))  out_val_d = req_wdata;
      if (req_addr == ADDR_W'(OFS_INV_MASK)) inv_d     = req_wdata;
      for (int k = 0; k < KINDS; k++) begin
        if (req_addr == ADDR_W'(en_ofs(k))) ie_d[k] = req_wdata;
      end
    end
  end

  assign cfg_upd = wr_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_en_q   <= '0;
      out_en_q  <= '0;
      out_val_q <= '0;
      inv_q     <= '0;
      ie_q      <= '0;
    end else if (cfg_upd) begin
      in_en_q   <= in_en_d;
      out_en_q  <= out_en_d;
      out_val_q <= out_val_d;
      inv_q     <= inv_d;
      ie_q      <= ie_d;
    end
  end

  // ---------------- read path ----------------
  always_comb begin
    rdata_d = '0;
    if (req_addr == ADDR_W'(OFS_IN_VAL))   rdata_d = in_val;
    if (req_addr == ADDR_W'(OFS_IN_EN))    rdata_d = in_en_q;
    if (req_addr == ADDR_W'(OFS_OUT_EN))   rdata_d = out_en_q;
    if (req_addr == ADDR_W'(OFS_OUT_VAL))  rdata_d = out_val_q;
    if (req_addr == ADDR_W'(OFS_INV_MASK)) rdata_d = inv_q;
    for (int k = 0; k < KINDS; k++) begin
      if (req_addr == ADDR_W'(en_ofs(k)))   rdata_d = ie_q[k];
      if (req_addr == ADDR_W'(pend_ofs(k))) rdata_d = pend[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_stb) rdata_q <= rdata_d;
  end

  assign rsp_rdata = rdata_q;

  // ---------------- pad drive and interrupt ----------------
  assign pad_out = (out_val_q ^ inv_q) & out_en_q;
  assign pad_oe  = out_en_q;

  always_comb begin
    logic [W-1:0] hit;
    hit = '0;
    for (int k = 0; k < KINDS; k++) hit = hit | (pend[k] & ie_q[k]);
    irq = |hit;
  end

  AST_PAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_stb) |-> ($stable(pad_out) && $stable(pad_oe))); // R2

  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_stb)); // R8

endmodule

// File: tb/tb_gpio4i.sv
module tb_gpio4i;

  localparam logic [7:0] A_IN_VAL = 8'h00, A_IN_EN = 8'h04, A_OUT_EN = 8'h08,
                         A_OUT_VAL = 8'h0C, A_RISE_EN = 8'h18, A_RISE_P = 8'h1C,
                         A_FALL_P = 8'h24, A_HIGH_EN = 8'h28, A_HIGH_P = 8'h2C,
                         A_LOW_P = 8'h34, A_INV = 8'h40;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [7:0]  req_addr;
  logic [31:0] req_wdata;
  logic [31:0] rsp_rdata, pad_out, pad_oe, pad_in;
  logic        irq;
  logic [31:0] ext;
  logic [31:0] rd;
  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  // loopback: driven pins feed back, others follow the bench
  assign pad_in = (pad_out & pad_oe) | (ext & ~pad_oe);

  gpio4i dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every task starts and ends just after a falling edge
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk); @(negedge clk);
    d = rsp_rdata;
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 pad_oe", pad_oe, 32'h0);
    chk("R1 pad_out", pad_out, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    bus_read(A_IN_VAL, rd);  chk("R1 in_val", rd, 32'h0);
    bus_read(A_RISE_P, rd);  chk("R1 rise pend", rd, 32'h0);
    bus_read(A_LOW_P, rd);   chk("R1 low pend", rd, 32'hFFFF_FFFF);
  endtask

  task automatic t_output;
    bus_write(A_OUT_EN, 32'hFF00_FF00);
    bus_write(A_OUT_VAL, 32'h1234_5678);
    bus_write(A_INV, 32'h0F0F_0000);
    chk("R2 pad_out", pad_out, (32'h1234_5678 ^ 32'h0F0F_0000) & 32'hFF00_FF00);
    chk("R2 pad_oe", pad_oe, 32'hFF00_FF00);
    bus_read(A_INV, rd); chk("R2 mask readback", rd, 32'h0F0F_0000);
    chk("R2 pad_out after read", pad_out, 32'h1D00_5600);
    bus_write(A_OUT_EN, 32'h0);
    bus_write(A_OUT_VAL, 32'h0);
    bus_write(A_INV, 32'h0);
    chk("R2 pad_out disabled", pad_out, 32'h0);
  endtask

  task automatic t_sync_gate;
    bus_write(A_IN_EN, 32'h0000_FFFF);
    idle(4);
    ext = 32'hA5A5_A5A5;
    bus_read(A_IN_VAL, rd); chk("R4 read at A", rd, 32'h0);
    bus_read(A_IN_VAL, rd); chk("R4 read at A+1", rd, 32'h0);
    bus_read(A_IN_VAL, rd); chk("R4 R3 read at A+2 gated", rd, 32'h0000_A5A5);
  endtask

  task automatic t_edges;
    ext = 32'h0;
    bus_write(A_IN_EN, 32'hFFFF_FFFF);
    idle(6);
    bus_write(A_RISE_P, 32'hFFFF_FFFF);
    bus_write(A_FALL_P, 32'hFFFF_FFFF);
    ext = 32'h0000_00F0;
    idle(6);
    bus_read(A_RISE_P, rd); chk("R5 rise pend", rd, 32'h0000_00F0);
    bus_read(A_FALL_P, rd); chk("R5 no fall", rd, 32'h0);
    chk("R5 irq off w/o enable", {31'h0, irq}, 32'h0);
    ext = 32'h0;
    idle(6);
    bus_read(A_FALL_P, rd); chk("R5 fall pend", rd, 32'h0000_00F0);
  endtask

  task automatic t_w1c;
    bus_write(A_RISE_P, 32'h0000_0030);
    bus_read(A_RISE_P, rd); chk("R6 partial clear", rd, 32'h0000_00C0);
    bus_write(A_RISE_P, 32'h0);
    bus_read(A_RISE_P, rd); chk("R6 zero write keeps", rd, 32'h0000_00C0);
  endtask

  task automatic t_level;
    ext = 32'h0000_000F;
    idle(6);
    bus_write(A_HIGH_P, 32'hFFFF_FFFF);
    bus_read(A_HIGH_P, rd); chk("R7 high reasserts", rd, 32'h0000_000F);
    bus_write(A_LOW_P, 32'hFFFF_FFFF);
    bus_read(A_LOW_P, rd);  chk("R7 low reasserts", rd, 32'hFFFF_FFF0);
  endtask

  task automatic t_irq;
    bus_write(A_RISE_P, 32'hFFFF_FFFF);
    bus_write(A_FALL_P, 32'hFFFF_FFFF);
    chk("R8 no enables", {31'h0, irq}, 32'h0);
    bus_write(A_HIGH_EN, 32'h0000_0001);
    chk("R8 high enabled", {31'h0, irq}, 32'h1);
    bus_write(A_HIGH_EN, 32'h0);
    chk("R8 enable cleared", {31'h0, irq}, 32'h0);
    bus_write(A_RISE_EN, 32'h0000_0100);
    ext = ext | 32'h0000_0100;
    idle(6);
    chk("R8 rise irq", {31'h0, irq}, 32'h1);
    bus_write(A_RISE_P, 32'h0000_0100);
    chk("R8 pending cleared", {31'h0, irq}, 32'h0);
    bus_write(A_RISE_EN, 32'h0);
  endtask

  task automatic t_gate_fall;
    bus_write(A_FALL_P, 32'hFFFF_FFFF);
    bus_write(A_LOW_P, 32'hFFFF_FFFF);
    bus_write(A_IN_EN, 32'hFFFF_FEF0);
    idle(6);
    bus_read(A_FALL_P, rd); chk("R9 fall from disable", rd, 32'h0000_010F);
    bus_read(A_LOW_P, rd);  chk("R9 low from disable", rd & 32'h0000_010F, 32'h0000_010F);
  endtask

  task automatic t_race;
    ext = 32'h0;
    bus_write(A_IN_EN, 32'hFFFF_FFFF);
    idle(6);
    bus_write(A_RISE_P, 32'hFFFF_FFFF);
    ext = 32'h1;
    idle(6);
    bus_read(A_RISE_P, rd); chk("R10 setup", rd, 32'h1);
    ext = 32'h3;
    idle(2);
    bus_write(A_RISE_P, 32'h3);   // lands on the edge that records pin 1
    bus_read(A_RISE_P, rd); chk("R10 set beats clear", rd, 32'h2);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; ext = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_output();
    t_sync_gate();
    t_edges();
    t_w1c();
    t_level();
    t_irq();
    t_gate_fall();
    t_race();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule